// File: doc/BRIEF.md
# Guarded Saturating Multiply-Accumulate Unit

This block is the arithmetic core of a fixed-point filter or correlator datapath. On each enabled clock cycle it multiplies two signed 16-bit two's-complement operands into a full 32-bit product. It then adds that product into a 40-bit accumulator. The 8 bits above the product width act as guard bits, so a long run of products can be summed without the running total overflowing partway through.

The accumulator is always read out as a 32-bit result. A mode input selects how a total outside the 32-bit signed range is presented:

- **Wrap mode** passes the low 32 bits through, so a large positive total shows up as a negative number and a large negative total shows up as a positive one.
- **Saturate mode** replaces the total with the nearest 32-bit limit.

A sticky overflow flag records that the running sum left the 32-bit range at some point since the last clear.

A clear input starts a new sum. When clear and accumulate are raised together, the accumulator is loaded with the current product alone, so back-to-back sums need no idle cycle between them.

Top module: `gmac_unit`

## Requirements
- R1: After reset is released, the accumulator is zero, `result_o` reads 0 and `ovf_o` is 0.
- R2: The product is the exact signed 32-bit product of the operands. The case -32768 × -32768 = 0x40000000 is included and is not clipped.
- R3: With `acc_en_i`=1 and `clr_i`=0, the accumulator adds the product at the next clock edge, one step per cycle. With both low, the accumulator holds its value.
- R4: With `clr_i`=1 and `acc_en_i`=0, the next edge sets the accumulator to zero and clears `ovf_o`.
- R5: With `clr_i`=1 and `acc_en_i`=1, the next edge loads the accumulator with the current product alone and clears `ovf_o`.
- R6: The accumulator is 40 bits wide and its sign extends through bits [39:31]. A total that exceeds the 32-bit range and later returns into it reads back exactly.
- R7: With `sat_mode_i`=0 (wrap), `result_o` is accumulator bits [31:0].
- R8: With `sat_mode_i`=1 (saturate), `result_o` depends on accumulator bits [39:31]:
  - if they are all equal, `result_o` is bits [31:0];
  - otherwise, if bit 39 is 0, `result_o` is 0x7FFFFFFF;
  - otherwise, if bit 39 is 1, `result_o` is 0x80000000.
- R9: `ovf_o` becomes 1 at the same edge at which the accumulator first holds an out-of-range value (bits [39:31] not all equal). It stays 1 until a clear, even after the total returns into range.
- R10: `sat_mode_i` affects only the readout. Changing it changes neither the accumulator nor `ovf_o`, and `result_o` follows the mode in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Start a new sum (zero, or load product when enabled) |
| acc_en_i | input | 1 | Accumulate the current product at this edge |
| sat_mode_i | input | 1 | Readout mode: 0 wrap, 1 saturate |
| op_a_i | input | 16 | Signed operand A |
| op_b_i | input | 16 | Signed operand B |
| result_o | output | 32 | Narrowed accumulator readout |
| ovf_o | output | 1 | Sticky out-of-range flag |

## Verification
The hardest situation to reach is a total that lies beyond the 32-bit range but inside the guard bits. Reaching it needs a run of near-maximal products of one sign, because no single product can leave the range. The stimulus chains four -32768 × -32768 products to reach +2^32, and three -32768 × 32767 products to go below -2^31. It then adds products of the opposite sign to bring the total back into range. At each point the mode is toggled to show both readouts of the same stored value, and a randomized phase with wide operands revisits these regions against a 64-bit model.

// File: rtl/gmac_pkg.sv
package gmac_pkg;
  localparam int unsigned OPERAND_W = 16;
  localparam int unsigned GUARD_W   = 8;

  typedef enum logic {
    READ_WRAP = 1'b0,
    READ_SAT  = 1'b1
  } gmac_read_e;
endpackage

// File: rtl/gmac_mult.sv
module gmac_mult #(
  parameter int unsigned OP_W = 16,
  localparam int unsigned PROD_W = 2 * OP_W
) (
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [PROD_W-1:0] prod_o
);
  function automatic logic [PROD_W-1:0] smul(input logic [OP_W-1:0] x,
                                             input logic [OP_W-1:0] y);
    logic signed [PROD_W-1:0] xs, ys;
    xs = PROD_W'(signed'(x));
    ys = PROD_W'(signed'(y));
    return xs * ys;
  endfunction

  assign prod_o = smul(a_i, b_i);
endmodule

// File: rtl/gmac_acc.sv
module gmac_acc #(
  parameter int unsigned PROD_W = 32,
  parameter int unsigned GUARD_W = 8,
  localparam int unsigned ACC_W = PROD_W + GUARD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic [ACC_W-1:0]  acc_d_o,
  output logic [ACC_W-1:0]  acc_q_o,
  output logic              flag_q_o
);
  function automatic logic [ACC_W-1:0] widen(input logic [PROD_W-1:0] p);
    return {{GUARD_W{p[PROD_W-1]}}, p};
  endfunction

  function automatic logic escapes(input logic [ACC_W-1:0] v);
    logic [GUARD_W:0] top;
    top = v[ACC_W-1:PROD_W-1];
    return !((&top) || !(|top));
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic             flag_q;
  logic [ACC_W-1:0] acc_d;
  logic             flag_d;

  always_comb begin
    acc_d = acc_q;
    if (clr_i && en_i)      acc_d = widen(prod_i);
    else if (clr_i)         acc_d = '0;
    else if (en_i)          acc_d = acc_q + widen(prod_i);
    flag_d = (clr_i ? 1'b0 : flag_q) | escapes(acc_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      flag_q <= flag_d;
    end
  end

  assign acc_d_o  = acc_d;
  assign acc_q_o  = acc_q;
  assign flag_q_o = flag_q;
endmodule

// File: rtl/gmac_readout.sv
module gmac_readout
  import gmac_pkg::*;
#(
  parameter int unsigned PROD_W = 32,
  parameter int unsigned GUARD_W = 8,
  localparam int unsigned ACC_W = PROD_W + GUARD_W
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic              sat_i,
  output logic [PROD_W-1:0] res_o,
  output logic              oor_o
);
  localparam logic [PROD_W-1:0] POS_LIM = {1'b0, {(PROD_W-1){1'b1}}};
  localparam logic [PROD_W-1:0] NEG_LIM = {1'b1, {(PROD_W-1){1'b0}}};

  function automatic logic out_of_range(input logic [ACC_W-1:0] v);
    logic [GUARD_W:0] top;
    top = v[ACC_W-1:PROD_W-1];
    return !((&top) || !(|top));
  endfunction

  function automatic logic [PROD_W-1:0] narrow(input logic [ACC_W-1:0] v,
                                               input gmac_read_e m);
    if (m == READ_SAT && out_of_range(v))
      return v[ACC_W-1] ? NEG_LIM : POS_LIM;
    return v[PROD_W-1:0];
  endfunction

  assign oor_o = out_of_range(acc_i);
  assign res_o = narrow(acc_i, gmac_read_e'(sat_i));
endmodule

// File: rtl/gmac_unit.sv
module gmac_unit
  import gmac_pkg::*;
#(
  parameter int unsigned OP_W = OPERAND_W,
  parameter int unsigned GRD_W = GUARD_W,
  localparam int unsigned PROD_W = 2 * OP_W,
  localparam int unsigned ACC_W = PROD_W + GRD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              acc_en_i,
  input  logic              sat_mode_i,
  input  logic [OP_W-1:0]   op_a_i,
  input  logic [OP_W-1:0]   op_b_i,
  output logic [PROD_W-1:0] result_o,
  output logic              ovf_o
);
  logic [PROD_W-1:0] prod_w;
  logic [ACC_W-1:0]  acc_next_w;
  logic [ACC_W-1:0]  acc_w;
  logic              sticky_w;
  logic              acc_oor_w;

  gmac_mult #(.OP_W(OP_W)) u_mult (
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .prod_o (prod_w)
  );

  gmac_acc #(.PROD_W(PROD_W), .GUARD_W(GRD_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_i),
    .en_i     (acc_en_i),
    .prod_i   (prod_w),
    .acc_d_o  (acc_next_w),
    .acc_q_o  (acc_w),
    .flag_q_o (sticky_w)
  );

  gmac_readout #(.PROD_W(PROD_W), .GUARD_W(GRD_W)) u_read (
    .acc_i (acc_w),
    .sat_i (sat_mode_i),
    .res_o (result_o),
    .oor_o (acc_oor_w)
  );

  assign ovf_o = sticky_w;
endmodule

// File: rtl/gmac_unit_checker.sv
module gmac_unit_checker #(
  parameter int unsigned PROD_W = 32,
  parameter int unsigned ACC_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic              acc_en_i,
  input logic              sat_mode_i,
  input logic [PROD_W-1:0] prod_w,
  input logic [ACC_W-1:0]  acc_w,
  input logic              acc_oor_w,
  input logic [PROD_W-1:0] result_o,
  input logic              ovf_o
);
  localparam int unsigned GW = ACC_W - PROD_W;

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !acc_en_i) |=> $stable(acc_w)); // R3

  AST_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && acc_en_i) |=>
      acc_w == $past(acc_w) + {{GW{$past(prod_w[PROD_W-1])}}, $past(prod_w)}); // R3

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !acc_en_i) |=> (acc_w == '0 && !ovf_o)); // R4

  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && acc_en_i) |=>
      acc_w == {{GW{$past(prod_w[PROD_W-1])}}, $past(prod_w)}); // R5

  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_mode_i |-> result_o == acc_w[PROD_W-1:0]); // R7

  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_mode_i && acc_oor_w) |->
      result_o == (acc_w[ACC_W-1] ? {1'b1, {(PROD_W-1){1'b0}}}
                                  : {1'b0, {(PROD_W-1){1'b1}}})); // R8

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_oor_w |-> ovf_o); // R9

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clr_i) |=> ovf_o); // R9
endmodule

bind gmac_unit gmac_unit_checker #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_i      (clr_i),
  .acc_en_i   (acc_en_i),
  .sat_mode_i (sat_mode_i),
  .prod_w     (prod_w),
  .acc_w      (acc_w),
  .acc_oor_w  (acc_oor_w),
  .result_o   (result_o),
  .ovf_o      (ovf_o)
);

// File: tb/gmac_unit_bench.sv
module gmac_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0;
  logic        acc_en_i = 1'b0;
  logic        sat_mode_i = 1'b0;
  logic [15:0] op_a_i = '0;
  logic [15:0] op_b_i = '0;
  logic [31:0] result_o;
  logic        ovf_o;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] res;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  longint m_acc = 0;
  bit     m_flag = 0;

  always #10 clk = ~clk;

  gmac_unit u_gmac_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .acc_en_i   (acc_en_i),
    .sat_mode_i (sat_mode_i),
    .op_a_i     (op_a_i),
    .op_b_i     (op_b_i),
    .result_o   (result_o),
    .ovf_o      (ovf_o)
  );

  function automatic bit beyond32(longint v);
    return (v > 64'sd2147483647) || (v < -64'sd2147483648);
  endfunction

  function automatic logic [31:0] expect_read(longint v, bit sat);
    if (sat && beyond32(v)) return (v < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
    return v[31:0];
  endfunction

  task automatic check(string tag, logic [31:0] gr, logic go,
                       logic [31:0] er, logic eo);
    n_cmp++;
    if (gr !== er || go !== eo) begin
      n_bad++;
      $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
               tag, gr, go, er, eo);
    end
  endtask

  task automatic step(string tag, int a, int b, bit en, bit clr, bit sat);
    longint p;
    @(negedge clk);
    op_a_i = 16'(a);
    op_b_i = 16'(b);
    acc_en_i = en;
    clr_i = clr;
    sat_mode_i = sat;
    p = longint'(signed'(16'(a))) * longint'(signed'(16'(b)));
    if (clr && en)  m_acc = p;
    else if (clr)   m_acc = 0;
    else if (en)    m_acc = m_acc + p;
    m_acc = (m_acc <<< 24) >>> 24;
    if (clr) m_flag = 0;
    if (beyond32(m_acc)) m_flag = 1;
    sb_q.push_back('{expect_read(m_acc, sat), m_flag, tag});
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, result_o, ovf_o, e.res, e.ovf);
    end
  end

  initial begin
    #4_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: result=%h ovf=%b expected result=run end", result_o, ovf_o);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", result_o, ovf_o, 32'h0, 1'b0);

    step("R5 clr+en loads product", 3, 4, 1, 1, 0);
    step("R3 accumulate negative", -5, 7, 1, 0, 0);
    step("R3 hold when disabled", 1000, 1000, 0, 0, 0);
    step("R4 clear", 9, 9, 0, 1, 0);
    step("R2 max-negative product", -32768, -32768, 1, 1, 0);
    step("R3 second max product", -32768, -32768, 1, 0, 0);
    step("R7 wrap past max", -32768, -32768, 1, 0, 0);
    step("R10 sat view same acc", 0, 0, 0, 0, 1);
    step("R7 wrap at 2^32", -32768, -32768, 1, 0, 0);
    step("R8 saturate positive", 0, 0, 0, 0, 1);
    step("R10 back to wrap", 0, 0, 0, 0, 0);
    step("R6 return toward range", -32768, 32767, 1, 0, 1);
    step("R6 still beyond", -32768, 32767, 1, 0, 1);
    step("R6 R9 back in range, flag sticky", -32768, 32767, 1, 0, 1);
    step("R9 sticky in wrap", 0, 0, 0, 0, 0);
    step("R4 clear drops flag", 0, 0, 0, 1, 1);
    step("R5 load negative product", -32768, 32767, 1, 1, 1);
    step("R3 negative sum", -32768, 32767, 1, 0, 1);
    step("R8 saturate negative", -32768, 32767, 1, 0, 1);
    step("R7 wrap below min", 0, 0, 0, 0, 0);
    step("R5 clr+en restarts and clears flag", 2, -3, 1, 1, 0);

    for (int i = 0; i < 600; i++) begin
      int a, b;
      bit clr, en, sat;
      a = $urandom_range(0, 3) == 0 ? -32768 : int'($urandom_range(0, 65535)) - 32768;
      b = $urandom_range(0, 3) == 0 ? -32768 : int'($urandom_range(0, 65535)) - 32768;
      clr = ($urandom_range(0, 39) == 0);
      en  = ($urandom_range(0, 7) != 0);
      sat = $urandom_range(0, 1) == 1;
      step("R3 R8 random", a, b, en, clr, sat);
    end

    @(negedge clk);
    acc_en_i = 1'b0;
    clr_i = 1'b0;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule